// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit virtual address into a physical page address by walking a radix page table held in memory. A one-cycle start pulse hands it the virtual address. The walk then reads up to four directory levels and one leaf level through a simple read port that allows one request at a time. The result comes back as a one-cycle done pulse together with a hit flag, a write-permission flag and a page-aligned physical address.

The caller supplies, as static configuration, a shift and an index width for every level and two root directory bases. Bit 63 of the virtual address chooses between the two bases. A directory entry with its huge flag set ends the walk early and serves as the leaf. The block is meant to sit beside a translation cache and service its misses, or to answer debug lookups for mappings that are not cached.

Top module: `page_walker`

## Requirements
- R1: The root base is `rootHi` when bit 63 of the latched virtual address is 1 and `rootLo` otherwise. Bits at and above `PA_WIDTH` are cleared from the root base before it is used.
- R2: Directory levels are handled in the order `LEVELS` down to 1. A level whose `levelWidth` is 0 issues no read. Any other level reads address `base | (((va >> levelShift[l]) & ((1 << levelWidth[l]) - 1)) << 3)`. The returned data, with bits at and above `PA_WIDTH` cleared, becomes the next base.
- R3: If no fetched directory entry has the huge flag set, exactly one more read is made using the level-0 shift and width. Its unmasked data is the leaf entry, and the level-0 shift is the final shift.
- R4: A fetched directory entry with bit 6 (huge) set ends the directory phase with no leaf read. That masked entry becomes the leaf with bits 14:13 (level field) and bit 6 cleared. If bit 12 (huge-global) is set, it is cleared and bit 7 (global) is set. The shift of that level is the final shift.
- R5: If leaf bit 0 (valid) is clear, the walk reports `hit`=0, `writable`=0 and `physAddr`=0.
- R6: On a hit, `writable` equals leaf bit 1 (dirty). When that bit is clear the page is read-only.
- R7: On a hit, `physAddr` is computed as follows. The leaf is added to the bits of `va & PA mask` that lie below the final shift. Bits 63, 62 and 61 of the sum are then cleared, and so are the low `PAGE_SHIFT` bits.
- R8: At most one read is outstanding. A request is not raised again until its response has arrived, and `memReqAddr` holds steady while `memReqValid` waits for `memReqReady`.
- R9: `done` is high for exactly one cycle per walk. `hit`, `writable` and `physAddr` are valid in that cycle and keep their values until the next walk finishes.
- R10: A `start` pulse that arrives while a walk is in progress is ignored. It changes neither the reads of the current walk nor its result, and it starts no further walk.
- R11: After reset `done` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; only taken while idle |
| vaddr | input | 64 | Virtual address, sampled with start |
| rootLo | input | 64 | Root directory base for addresses with bit 63 clear |
| rootHi | input | 64 | Root directory base for addresses with bit 63 set |
| levelShift | input | (LEVELS+1)*SHIFT_W | Index shift for each level, level 0 is the leaf |
| levelWidth | input | (LEVELS+1)*SHIFT_W | Index width for each level, 0 skips a directory level |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Byte address of the 8-byte entry |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A valid mapping was found |
| writable | output | 1 | Mapping allows writes |
| physAddr | output | 64 | Page-aligned physical address |

## Verification
The bench builds the walker with its default parameters: a 48-bit physical address, 4 KiB pages, four directory levels and 6-bit shift and width fields. The configured shifts are 12, 21, 30, 39 and 48. The top-level width can be switched between 0 and 9, and a middle level or every directory level can be zeroed, so the bench covers skipped levels, five-read walks and leaf-only walks. A 48-bit physical width leaves room above the address field for root and directory values with stray high bits, which tests the masking. Leaf entries set the three attribute bits at the top of the word and bits between 48 and 60 to test the final clean-up. A huge entry at level 2 carries the level, huge and huge-global flags, so any missed fold changes bits 12 to 14 of the result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ValidBit      = 0;
  localparam int DirtyBit      = 1;
  localparam int HugeBit       = 6;
  localparam int GlobalBit     = 7;
  localparam int HugeGlobalBit = 12;
  localparam int LevelLoBit    = 13;
  localparam int LevelHiBit    = 14;
  localparam int NoReadBit     = 61;
  localparam int NoExecBit     = 62;
  localparam int PrivRestBit   = 63;

  typedef struct packed {
    logic latchVa;
    logic loadRoot;
    logic decLevel;
    logic captureDir;
    logic captureLeaf;
    logic finalize;
  } ctrlStrobes_t;

  typedef struct packed {
    logic levelZero;
    logic widthZero;
    logic respHuge;
  } dpStatus_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROOT,
    ST_SCAN,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_CHECK,
    ST_DONE
  } walkState_e;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         memReqReady,
  input  logic         memRespValid,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         memReqValid,
  output logic         done
);

  walkState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.latchVa = 1'b1;
          nextState       = ST_ROOT;
        end
      end
      ST_ROOT: begin
        strobes.loadRoot = 1'b1;
        nextState        = ST_SCAN;
      end
      ST_SCAN: begin
        if (status.levelZero)      nextState = ST_LEAF_REQ;
        else if (status.widthZero) strobes.decLevel = 1'b1;
        else                       nextState = ST_DIR_REQ;
      end
      ST_DIR_REQ: begin
        if (memReqReady) nextState = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRespValid) begin
          strobes.captureDir = 1'b1;
          if (status.respHuge) begin
            nextState = ST_CHECK;
          end else begin
            strobes.decLevel = 1'b1;
            nextState        = ST_SCAN;
          end
        end
      end
      ST_LEAF_REQ: begin
        if (memReqReady) nextState = ST_LEAF_WAIT;
      end
      ST_LEAF_WAIT: begin
        if (memRespValid) begin
          strobes.captureLeaf = 1'b1;
          nextState           = ST_CHECK;
        end
      end
      ST_CHECK: begin
        strobes.finalize = 1'b1;
        nextState        = ST_DONE;
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_DIR_REQ) || (state == ST_LEAF_REQ);
  assign done        = (state == ST_DONE);

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int PA_WIDTH   = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int LEVELS     = 4,
  parameter int SHIFT_W    = 6
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobes_t                    strobes,
  input  logic [63:0]                     vaddr,
  input  logic [63:0]                     rootLo,
  input  logic [63:0]                     rootHi,
  input  logic [LEVELS:0][SHIFT_W-1:0]    levelShift,
  input  logic [LEVELS:0][SHIFT_W-1:0]    levelWidth,
  input  logic [63:0]                     memRespData,
  output dpStatus_t                       status,
  output logic [63:0]                     memReqAddr,
  output logic                            hit,
  output logic                            writable,
  output logic [63:0]                     physAddr
);

  localparam int LVL_W = $clog2(LEVELS + 1);
  localparam logic [LVL_W-1:0] TOP_LEVEL = LVL_W'(LEVELS);
  localparam logic [63:0] PAGE_MASK = ~((64'd1 << PAGE_SHIFT) - 64'd1);
  localparam logic [63:0] ATTR_MASK =
    ~((64'd1 << PrivRestBit) | (64'd1 << NoExecBit) | (64'd1 << NoReadBit));

  logic [63:0] paMask;
  generate
    if (PA_WIDTH >= 64) begin : g_fullPa
      assign paMask = '1;
    end else begin : g_narrowPa
      assign paMask = (64'd1 << PA_WIDTH) - 64'd1;
    end
  endgenerate

  logic [63:0]        vaReg, baseReg, pteReg;
  logic [SHIFT_W-1:0] offShift;
  logic [LVL_W-1:0]   level;

  logic [SHIFT_W-1:0] curShift, curWidth;
  logic [63:0]        idxMask, entryIdx, respMasked;

  assign curShift   = levelShift[level];
  assign curWidth   = levelWidth[level];
  assign idxMask    = (64'd1 << curWidth) - 64'd1;
  assign entryIdx   = (vaReg >> curShift) & idxMask;
  assign memReqAddr = baseReg | (entryIdx << 3);
  assign respMasked = memRespData & paMask;

  assign status.levelZero = (level == '0);
  assign status.widthZero = (curWidth == '0);
  assign status.respHuge  = respMasked[HugeBit];

  function automatic logic [63:0] foldHuge(input logic [63:0] entry);
    logic [63:0] r;
    r = entry;
    r[LevelHiBit:LevelLoBit] = '0;
    r[HugeBit] = 1'b0;
    if (r[HugeGlobalBit]) begin
      r[HugeGlobalBit] = 1'b0;
      r[GlobalBit]     = 1'b1;
    end
    return r;
  endfunction

  logic [63:0] offMask, pageSum, cleanAddr;
  assign offMask   = (64'd1 << offShift) - 64'd1;
  assign pageSum   = pteReg + ((vaReg & paMask) & offMask);
  assign cleanAddr = pageSum & ATTR_MASK & PAGE_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseReg  <= '0;
      pteReg   <= '0;
      offShift <= '0;
      level    <= '0;
      hit      <= 1'b0;
      writable <= 1'b0;
      physAddr <= '0;
    end else begin
      if (strobes.latchVa) vaReg <= vaddr;
      if (strobes.loadRoot) begin
        baseReg <= (vaReg[63] ? rootHi : rootLo) & paMask;
        level   <= TOP_LEVEL;
      end
      if (strobes.decLevel) level <= level - 1'b1;
      if (strobes.captureDir) begin
        baseReg <= respMasked;
        if (respMasked[HugeBit]) begin
          pteReg   <= foldHuge(respMasked);
          offShift <= curShift;
        end
      end
      if (strobes.captureLeaf) begin
        pteReg   <= memRespData;
        offShift <= curShift;
      end
      if (strobes.finalize) begin
        hit      <= pteReg[ValidBit];
        writable <= pteReg[ValidBit] & pteReg[DirtyBit];
        physAddr <= pteReg[ValidBit] ? cleanAddr : 64'd0;
      end
    end
  end

endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int PA_WIDTH   = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int LEVELS     = 4,
  parameter int SHIFT_W    = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [63:0]                  vaddr,
  input  logic [63:0]                  rootLo,
  input  logic [63:0]                  rootHi,
  input  logic [LEVELS:0][SHIFT_W-1:0] levelShift,
  input  logic [LEVELS:0][SHIFT_W-1:0] levelWidth,
  output logic                         memReqValid,
  input  logic                         memReqReady,
  output logic [63:0]                  memReqAddr,
  input  logic                         memRespValid,
  input  logic [63:0]                  memRespData,
  output logic                         done,
  output logic                         hit,
  output logic                         writable,
  output logic [63:0]                  physAddr
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .status       (status),
    .strobes      (strobes),
    .memReqValid  (memReqValid),
    .done         (done)
  );

  ptw_datapath #(
    .PA_WIDTH   (PA_WIDTH),
    .PAGE_SHIFT (PAGE_SHIFT),
    .LEVELS     (LEVELS),
    .SHIFT_W    (SHIFT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .vaddr       (vaddr),
    .rootLo      (rootLo),
    .rootHi      (rootHi),
    .levelShift  (levelShift),
    .levelWidth  (levelWidth),
    .memRespData (memRespData),
    .status      (status),
    .memReqAddr  (memReqAddr),
    .hit         (hit),
    .writable    (writable),
    .physAddr    (physAddr)
  );

endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int PAGE_SHIFT = 12
) (
  input logic        clk,
  input logic        rstN,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [63:0] memReqAddr,
  input logic        memRespValid,
  input logic        done,
  input logic        hit,
  input logic        writable,
  input logic [63:0] physAddr
);

  logic pending;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            pending <= 1'b0;
    else if (memReqValid && memReqReady)  pending <= 1'b1;
    else if (memRespValid)                pending <= 1'b0;
  end

  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !memReqValid);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReqValid);

  assert_miss_clean_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !hit) |-> (physAddr == 64'd0 && !writable));

  assert_phys_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (physAddr[PAGE_SHIFT-1:0] == '0 && physAddr[63:61] == 3'b000));

endmodule

bind page_walker page_walker_chk #(.PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqAddr   (memReqAddr),
  .memRespValid (memRespValid),
  .done         (done),
  .hit          (hit),
  .writable     (writable),
  .physAddr     (physAddr)
);

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;

  localparam int PA_WIDTH = 48;
  localparam logic [63:0] PA_MASK = (64'd1 << PA_WIDTH) - 64'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [63:0] vaddr = '0, rootLo = '0, rootHi = '0;
  logic [4:0][5:0] levelShift, levelWidth;
  logic memReqValid, memReqReady = 1'b1;
  logic [63:0] memReqAddr;
  logic memRespValid = 1'b0;
  logic [63:0] memRespData = '0;
  logic done, hit, writable;
  logic [63:0] physAddr;

  always #4 clk = ~clk;

  page_walker dut (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr),
    .rootLo(rootLo), .rootHi(rootHi),
    .levelShift(levelShift), .levelWidth(levelWidth),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .done(done), .hit(hit), .writable(writable), .physAddr(physAddr)
  );

  int checks = 0, fails = 0;
  logic [63:0] respSeq [8];
  logic [63:0] logAddr [8];
  logic [63:0] expAddr [8];
  int logCount = 0, expCount = 0;
  logic expHit, expWr;
  logic [63:0] expPhys;
  bit toggleOn = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: answers reads in order from respSeq, one cycle after acceptance
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid && memReqReady) begin
        if (logCount < 8) logAddr[logCount] = memReqAddr;
        memRespData = (logCount < 8) ? respSeq[logCount] : 64'd0;
        logCount++;
        @(negedge clk);
        memRespValid = 1'b1;
        @(negedge clk);
        memRespValid = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (toggleOn) memReqReady = ~memReqReady;
      else          memReqReady = 1'b1;
    end
  end

  // expected walk computed from the requirements
  task automatic modelWalk(input logic [63:0] va);
    logic [63:0] base, pte, idx, sum;
    int sh;
    bit huge;
    expCount = 0; huge = 0; sh = 0; pte = '0;
    base = (va[63] ? rootHi : rootLo) & PA_MASK;
    for (int lvl = 4; lvl >= 1; lvl--) begin
      if (levelWidth[lvl] == 0) continue;
      idx = (va >> levelShift[lvl]) & ((64'd1 << levelWidth[lvl]) - 1);
      expAddr[expCount] = base | (idx << 3);
      base = respSeq[expCount] & PA_MASK;
      expCount++;
      if (base[6]) begin huge = 1; sh = int'(levelShift[lvl]); break; end
    end
    if (huge) begin
      pte = base;
      pte[14:13] = 2'b00;
      pte[6] = 1'b0;
      if (pte[12]) begin pte[12] = 1'b0; pte[7] = 1'b1; end
    end else begin
      idx = (va >> levelShift[0]) & ((64'd1 << levelWidth[0]) - 1);
      expAddr[expCount] = base | (idx << 3);
      pte = respSeq[expCount];
      expCount++;
      sh = int'(levelShift[0]);
    end
    expHit = pte[0];
    expWr  = pte[0] & pte[1];
    sum = pte + ((va & PA_MASK) & ((64'd1 << sh) - 1));
    sum[63:61] = 3'b000;
    sum[11:0] = '0;
    expPhys = pte[0] ? sum : 64'd0;
  endtask

  task automatic runWalk(input string tag, input logic [63:0] va, input bit busyStart);
    int n;
    int seenReads;
    modelWalk(va);
    logCount = 0;
    @(negedge clk);
    vaddr = va; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busyStart) begin
      repeat (3) @(negedge clk);
      vaddr = ~va; rootLo = rootLo ^ 64'h1000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    check({tag, " R9 done seen"}, done, 1'b1);
    check({tag, " R5 R6 hit"}, hit, expHit);
    check({tag, " R6 writable"}, writable, expWr);
    check({tag, " R7 physAddr"}, physAddr, expPhys);
    check({tag, " R2 R3 read count"}, logCount, expCount);
    for (int i = 0; i < expCount && i < 8; i++)
      check($sformatf("%s R1 R2 R3 read %0d address", tag, i), logAddr[i], expAddr[i]);
    @(negedge clk);
    check({tag, " R9 done one cycle"}, done, 1'b0);
    seenReads = logCount;
    repeat (5) @(negedge clk);
    check({tag, " R10 no extra reads"}, logCount, seenReads);
    check({tag, " R9 result held"}, physAddr, expPhys);
    if (busyStart) rootLo = rootLo ^ 64'h1000;
  endtask

  task automatic defaultCfg();
    levelShift = {6'd48, 6'd39, 6'd30, 6'd21, 6'd12};
    levelWidth = {6'd0,  6'd9,  6'd9,  6'd9,  6'd9};
  endtask

  task automatic testReset();
    check("R11 done in reset", done, 1'b0);
    check("R11 request in reset", memReqValid, 1'b0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 done after reset", done, 1'b0);
    check("R11 request after reset", memReqValid, 1'b0);
  endtask

  task automatic testLowRootMasking();
    rootLo = 64'h0004_0000_8000_0000;
    respSeq[0] = 64'h00F0_0000_0001_0000;
    respSeq[1] = 64'h0000_0000_0002_0000;
    respSeq[2] = 64'h0000_0000_0003_0000;
    respSeq[3] = 64'hE004_0000_ABCD_E003;
    runWalk("low root R1 R7", 64'h0000_0012_3456_7ABC, 0);
  endtask

  task automatic testHighRootReadOnly();
    rootHi = 64'h0000_0000_0040_0000;
    respSeq[0] = 64'h1000; respSeq[1] = 64'h2000; respSeq[2] = 64'h3000;
    respSeq[3] = 64'h0000_1234_5678_9001;
    runWalk("high root R1 R6", 64'h8000_0001_2345_6000, 0);
  endtask

  task automatic testHugeLevel2();
    rootLo = 64'h0000_0000_0050_0000;
    respSeq[0] = 64'h0000_0000_0001_0000;
    respSeq[1] = 64'h0000_0000_4000_7043;
    runWalk("huge R4", 64'h0000_0000_5A5A_5123, 0);
  endtask

  task automatic testInvalidLeaf();
    rootLo = 64'h0000_0000_0060_0000;
    respSeq[0] = 64'h1000; respSeq[1] = 64'h2000; respSeq[2] = 64'h3000;
    respSeq[3] = 64'h0000_0000_1234_F002;
    runWalk("invalid R5", 64'h0000_0000_0000_3000, 0);
  endtask

  task automatic testFiveLevels();
    levelWidth[4] = 6'd9;
    rootLo = 64'h0000_0000_0070_0000;
    respSeq[0] = 64'h1000; respSeq[1] = 64'h2000; respSeq[2] = 64'h3000;
    respSeq[3] = 64'h4000; respSeq[4] = 64'h0000_0000_0777_7003;
    runWalk("five levels R2", 64'h0123_4567_89AB_C000, 0);
    defaultCfg();
  endtask

  task automatic testSkipMiddle();
    levelWidth[2] = 6'd0;
    rootLo = 64'h0000_0000_0080_0000;
    respSeq[0] = 64'h5000; respSeq[1] = 64'h6000;
    respSeq[2] = 64'h0000_0000_0ABC_D003;
    runWalk("skip level2 R2 R3", 64'h0000_00FF_FFFF_F123, 0);
    defaultCfg();
  endtask

  task automatic testLeafOnly();
    levelWidth = {6'd0, 6'd0, 6'd0, 6'd0, 6'd9};
    rootLo = 64'h0000_0000_0090_0000;
    respSeq[0] = 64'h0000_0000_0BBB_B001;
    runWalk("leaf only R3", 64'h0000_0000_0012_3456, 0);
    defaultCfg();
  endtask

  task automatic testStallAndBusyStart();
    rootLo = 64'h0000_0000_00A0_0000;
    respSeq[0] = 64'h1000; respSeq[1] = 64'h2000; respSeq[2] = 64'h3000;
    respSeq[3] = 64'h0000_0000_0CCC_C003;
    toggleOn = 1;
    runWalk("stall busy R8 R10", 64'h0000_0040_0080_1FFF, 1);
    toggleOn = 0;
  endtask

  initial begin
    defaultCfg();
    for (int i = 0; i < 8; i++) respSeq[i] = '0;
    testReset();
    testLowRootMasking();
    testHighRootReadOnly();
    testHugeLevel2();
    testInvalidLeaf();
    testFiveLevels();
    testSkipMiddle();
    testLeafOnly();
    testStallAndBusyStart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule